// File: doc/BRIEF.md
# Four-State Hard-Decision Viterbi Decoder

This block recovers message bits from a stream protected by the rate-one-half convolutional code with constraint length 3 and generator taps 111 and 101. Received code bits arrive in pairs, one pair per trellis step. For each step the decoder measures how far the pair is from each of the eight branch labels, using Hamming distance. It then runs add-compare-select into each of the four states. Every state keeps an accumulated distance and the full survivor path.

A frame is a sequence of pairs that ends with the pair carrying the frame-last flag. The sender terminates each frame with two zero message bits, so the encoder finishes in the all-zero state. When the last pair has been absorbed, the decoder takes the survivor that ends in the all-zero state. It drops the two tail bits and sends the remaining message bits out serially, earliest bit first. While that burst is being sent, the input is not looked at. After the burst the decoder is ready for a new frame, which starts again from the all-zero state.

Top module: `viterbi4_dec`

## Requirements
- R1: After reset, out_valid and out_last are low and stay low until a frame of at least three pairs has been completed.
- R2: in_pair[1] is the first received code bit, compared against the taps-111 parity (u xor newest xor older). in_pair[0] is the second bit, compared against the taps-101 parity (u xor older). An error-free terminated frame decodes to exactly its message bits.
- R3: The decoded bits are the maximum-likelihood path under Hamming branch metrics that ends in state a. States are numbered a=0, b=1, c=2, d=3, and the index is {older bit, newest bit}. On equal candidate distances the predecessor with the lower index wins. As a result, isolated channel errors are corrected.
- R4: Take a frame of L pairs with L at least 3. Starting in the cycle after its frame-last pair is accepted, the block emits L-2 bits, one per clock and without gaps, with the first message bit first. The two tail bits are never emitted.
- R5: A frame of one or two pairs produces no output bits.
- R6: Pairs presented while out_valid is high are ignored. They alter neither the current burst nor the next frame.
- R7: Every frame starts with state a at distance zero and the other states at the saturated maximum. Successive frames are decoded independently.
- R8: Accumulated distances saturate at their maximum value and never wrap. Within a frame the smallest accumulated distance never decreases.
- R9: out_last is high only together with out_valid, on the final bit of a burst. out_valid is low in the cycle after out_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received pair is present |
| in_pair | input | 2 | Received pair; bit 1 is the first code bit |
| in_last | input | 1 | The present pair is the last pair of the frame |
| out_valid | output | 1 | A decoded bit is present |
| out_bit | output | 1 | Decoded message bit |
| out_last | output | 1 | Final decoded bit of the frame |

## Verification
Suppose an add-compare-select unit picks the wrong predecessor or a distance wraps. The survivor kept for state a then holds a wrong bit, and that bit appears at out_bit within the burst that follows the frame-last pair. Comparing every output cycle against an independent trellis search exposes the fault at once, although the error itself arose at an earlier step. Frames with channel errors and with equal-distance competitors make such faults visible. A wrong step count or emitter index shows up as a burst of the wrong length or as a misplaced out_last. Accepting pairs while busy shows up as a corrupted next frame.

// File: rtl/viterbi4_pkg.sv
package viterbi4_pkg;

   localparam int NSTATE = 4;

   // code label of the branch leaving state st (index {older, newest}) on input u
   function automatic logic [1:0] branch_label(input logic [1:0] st, input logic u);
      return {u ^ st[0] ^ st[1], u ^ st[1]};
   endfunction

   function automatic logic [1:0] pair_distance(input logic [1:0] x, input logic [1:0] y);
      logic [1:0] d;
      d = x ^ y;
      return {1'b0, d[1]} + {1'b0, d[0]};
   endfunction

endpackage

// File: rtl/v4_branch_metric.sv
module v4_branch_metric
   import viterbi4_pkg::*;
(
   input  logic [1:0]                  rx_pair,
   output logic [NSTATE-1:0][1:0][1:0] bm
);

   for (genvar s = 0; s < NSTATE; s++) begin : g_state
      for (genvar u = 0; u < 2; u++) begin : g_input
         assign bm[s][u] = pair_distance(rx_pair, branch_label(2'(s), 1'(u)));
      end
   end

endmodule

// File: rtl/v4_acs.sv
module v4_acs #(
   parameter int METRIC_W = 8
) (
   input  logic [METRIC_W-1:0] pm_lo,
   input  logic [METRIC_W-1:0] pm_hi,
   input  logic [1:0]          bm_lo,
   input  logic [1:0]          bm_hi,
   output logic [METRIC_W-1:0] pm_new,
   output logic                pick_hi
);

   function automatic logic [METRIC_W-1:0] sat_add(input logic [METRIC_W-1:0] a,
                                                   input logic [1:0] b);
      logic [METRIC_W:0] s;
      s = {1'b0, a} + (METRIC_W+1)'(b);
      return s[METRIC_W] ? {METRIC_W{1'b1}} : s[METRIC_W-1:0];
   endfunction

   logic [METRIC_W-1:0] cand_lo, cand_hi;

   assign cand_lo = sat_add(pm_lo, bm_lo);
   assign cand_hi = sat_add(pm_hi, bm_hi);
   // strict compare: equal candidates keep the lower-index predecessor
   assign pick_hi = cand_hi < cand_lo;
   assign pm_new  = pick_hi ? cand_hi : cand_lo;

endmodule

// File: rtl/v4_paths.sv
module v4_paths
   import viterbi4_pkg::*;
#(
   parameter int PW = 34
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       advance,
   input  logic                       restart,
   input  logic [NSTATE-1:0]          pick_hi,
   output logic [NSTATE-1:0][PW-1:0]  path_nxt
);

   logic [NSTATE-1:0][PW-1:0] path_q;

   for (genvar n = 0; n < NSTATE; n++) begin : g_exch
      localparam int P_LO = n >> 1;
      localparam int P_HI = 2 + (n >> 1);
      localparam logic U  = 1'(n & 1);
      assign path_nxt[n] = pick_hi[n] ? {path_q[P_HI][PW-2:0], U}
                                      : {path_q[P_LO][PW-2:0], U};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         path_q <= '0;
      end else if (advance) begin
         path_q <= path_nxt;
      end
   end

endmodule

// File: rtl/v4_emit.sv
module v4_emit #(
   parameter int PW    = 34,
   parameter int IDX_W = $clog2(PW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PW-1:0]    load_path,
   input  logic [IDX_W-1:0] load_top,
   output logic             busy,
   output logic             bit_out,
   output logic             last_out
);

   logic [PW-1:0]    hold_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx_q  <= '0;
         hold_q <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         idx_q  <= load_top;
         hold_q <= load_path;
      end else if (busy) begin
         if (idx_q == IDX_W'(2)) busy <= 1'b0;
         else                    idx_q <= idx_q - 1'b1;
      end
   end

   assign bit_out  = hold_q[idx_q];
   assign last_out = busy && (idx_q == IDX_W'(2));

endmodule

// File: rtl/viterbi4_dec.sv
module viterbi4_dec
   import viterbi4_pkg::*;
#(
   parameter int MAX_MSG  = 32,
   parameter int METRIC_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [1:0] in_pair,
   input  logic       in_last,
   output logic       out_valid,
   output logic       out_bit,
   output logic       out_last
);

   localparam int PW    = MAX_MSG + 2;
   localparam int CNT_W = $clog2(PW + 1);
   localparam int IDX_W = $clog2(PW);

   if (MAX_MSG < 1) begin : g_bad_len
      $error("viterbi4_dec: MAX_MSG must be at least 1");
   end
   if (METRIC_W < 3) begin : g_bad_metric
      $error("viterbi4_dec: METRIC_W must be at least 3");
   end

   logic                              busy, step, frame_end;
   logic [NSTATE-1:0][1:0][1:0]       bm;
   logic [NSTATE-1:0][METRIC_W-1:0]   pm, pm_nxt;
   logic [NSTATE-1:0]                 pick_hi;
   logic [NSTATE-1:0][PW-1:0]         path_nxt;
   logic [CNT_W-1:0]                  step_cnt;
   logic [CNT_W:0]                    frame_len;
   logic                              load;
   logic [IDX_W-1:0]                  load_top;

   assign step      = in_valid && !busy;
   assign frame_end = step && in_last;

   function automatic logic [NSTATE-1:0][METRIC_W-1:0] start_metrics();
      logic [NSTATE-1:0][METRIC_W-1:0] m;
      for (int s = 0; s < NSTATE; s++) m[s] = {METRIC_W{1'b1}};
      m[0] = '0;
      return m;
   endfunction

   v4_branch_metric u_bm (
      .rx_pair (in_pair),
      .bm      (bm)
   );

   for (genvar n = 0; n < NSTATE; n++) begin : g_acs
      localparam int P_LO = n >> 1;
      localparam int P_HI = 2 + (n >> 1);
      localparam int U    = n & 1;
      v4_acs #(.METRIC_W(METRIC_W)) u_acs (
         .pm_lo   (pm[P_LO]),
         .pm_hi   (pm[P_HI]),
         .bm_lo   (bm[P_LO][U]),
         .bm_hi   (bm[P_HI][U]),
         .pm_new  (pm_nxt[n]),
         .pick_hi (pick_hi[n])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n || frame_end) begin
         pm <= start_metrics();
      end else if (step) begin
         pm <= pm_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || frame_end) begin
         step_cnt <= '0;
      end else if (step && step_cnt != CNT_W'(PW)) begin
         step_cnt <= step_cnt + 1'b1;
      end
   end

   v4_paths #(.PW(PW)) u_paths (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (step),
      .restart  (frame_end),
      .pick_hi  (pick_hi),
      .path_nxt (path_nxt)
   );

   assign frame_len = (CNT_W+1)'(step_cnt) + (CNT_W+1)'(1);
   assign load      = frame_end && (frame_len >= (CNT_W+1)'(3));
   assign load_top  = (frame_len > (CNT_W+1)'(PW)) ? IDX_W'(PW - 1)
                                                   : IDX_W'(frame_len - 1'b1);

   v4_emit #(.PW(PW), .IDX_W(IDX_W)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_path (path_nxt[0]),
      .load_top  (load_top),
      .busy      (busy),
      .bit_out   (out_bit),
      .last_out  (out_last)
   );

   assign out_valid = busy;

endmodule

// File: rtl/viterbi4_dec_chk.sv
module viterbi4_dec_chk #(
   parameter int METRIC_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    step,
   input logic                    frame_end,
   input logic                    out_valid,
   input logic                    out_last,
   input logic [4*METRIC_W-1:0]   pm_flat
);

   logic [METRIC_W-1:0] pm_min;
   always_comb begin
      pm_min = pm_flat[METRIC_W-1:0];
      for (int s = 1; s < 4; s++)
         if (pm_flat[s*METRIC_W +: METRIC_W] < pm_min) pm_min = pm_flat[s*METRIC_W +: METRIC_W];
   end

   assert_last_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_burst_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);

   assert_burst_gapless_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   assert_frame_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (pm_flat[METRIC_W-1:0] == '0 &&
                     pm_flat[4*METRIC_W-1:METRIC_W] == '1));

   assert_min_metric_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !frame_end) |=> pm_min >= $past(pm_min));

   assert_busy_ignores_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && in_valid) |=> $stable(pm_flat));

endmodule

bind viterbi4_dec viterbi4_dec_chk #(.METRIC_W(METRIC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .step      (step),
   .frame_end (frame_end),
   .out_valid (out_valid),
   .out_last  (out_last),
   .pm_flat   (pm)
);

// File: tb/viterbi4_dec_bench.sv
module viterbi4_dec_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] in_pair = 2'b00;
   logic       in_last = 1'b0;
   logic       out_valid, out_bit, out_last;

   int total = 0;
   int bad = 0;
   string cur_tag = "R1";
   bit exp_bits[$];
   bit exp_last[$];

   always #4 clk = ~clk;

   viterbi4_dec u_viterbi4_dec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pair(in_pair),
      .in_last(in_last), .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // behavioural trellis search: forward over every (state,input), lower state first
   task automatic model(input logic [1:0] pr[$]);
      int m[4];
      longint unsigned p[4];
      int nm[4];
      longint unsigned np[4];
      int len;
      len = pr.size();
      m = '{0, 1000000, 1000000, 1000000};
      p = '{0, 0, 0, 0};
      foreach (pr[k]) begin
         nm = '{1 << 30, 1 << 30, 1 << 30, 1 << 30};
         for (int s = 0; s < 4; s++) begin
            for (int u = 0; u < 2; u++) begin
               int ns, v1, v2, c;
               ns = ((s & 1) << 1) | u;
               v1 = u ^ (s & 1) ^ (s >> 1);
               v2 = u ^ (s >> 1);
               c = m[s] + (v1 != int'(pr[k][1])) + (v2 != int'(pr[k][0]));
               if (c < nm[ns]) begin
                  nm[ns] = c;
                  np[ns] = (p[s] << 1) | longint'(u);
               end
            end
         end
         m = nm;
         p = np;
      end
      if (len >= 3)
         for (int i = len - 1; i >= 2; i--) begin
            exp_bits.push_back(p[0][i]);
            exp_last.push_back(i == 2);
         end
   endtask

   function automatic void encode(input bit msg[$], ref logic [1:0] pr[$]);
      int s;
      bit u;
      s = 0;
      pr.delete();
      for (int i = 0; i < msg.size() + 2; i++) begin
         u = (i < msg.size()) ? msg[i] : 1'b0;
         pr.push_back({u ^ s[0] ^ s[1], u ^ s[1]});
         s = ((s & 1) << 1) | int'(u);
      end
   endfunction

   task automatic send(input logic [1:0] pr[$], input bit junk, input string tag);
      cur_tag = tag;
      model(pr);
      foreach (pr[i]) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_pair  = pr[i];
         in_last  = (i == pr.size() - 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      if (pr.size() >= 3) begin
         while (out_valid) begin
            if (junk) begin
               in_valid = 1'b1;
               in_pair  = 2'($urandom);
               in_last  = 1'($urandom);
            end
            @(negedge clk);
         end
         in_valid = 1'b0;
         in_last  = 1'b0;
      end else begin
         repeat (8) begin
            check(!out_valid, tag, "no output for short frame", int'(out_valid), 0);
            @(negedge clk);
         end
      end
      check(exp_bits.size() == 0, tag, "bits left unemitted", exp_bits.size(), 0);
      exp_bits.delete();
      exp_last.delete();
   endtask

   // per-clock comparison of the output stream against the model
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_last) check(out_valid, "R9", "out_last without out_valid", 0, 1);
         if (out_valid) begin
            if (exp_bits.size() == 0) begin
               check(1'b0, "R4", "unexpected output bit", 1, 0);
            end else begin
               bit eb, el;
               eb = exp_bits.pop_front();
               el = exp_last.pop_front();
               check(out_bit == eb, cur_tag, "decoded bit", int'(out_bit), int'(eb));
               check(out_last == el, "R9", "out_last position", int'(out_last), int'(el));
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
   end

   initial begin
      logic [1:0] pr[$];
      bit msg[$];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
      check(!out_last,  "R1", "out_last after reset",  int'(out_last), 0);

      // R2: clean frame, message 1010
      msg = '{1, 0, 1, 0};
      encode(msg, pr);
      check(pr[0] == 2'b11 && pr[1] == 2'b10 && pr[2] == 2'b00, "R2",
            "encoder sanity", int'(pr[1]), 2);
      send(pr, 0, "R2");

      // R3: received 01 00 01 then tail
      pr = '{2'b01, 2'b00, 2'b01, 2'b00, 2'b00};
      send(pr, 0, "R3");

      // R3: ties between equal-distance predecessors
      pr = '{2'b01, 2'b10, 2'b01, 2'b10, 2'b11, 2'b00};
      send(pr, 0, "R3");

      // R3: random message with isolated errors
      msg.delete();
      for (int i = 0; i < 20; i++) msg.push_back(1'($urandom));
      encode(msg, pr);
      pr[2] ^= 2'b10; pr[9] ^= 2'b01; pr[17] ^= 2'b10;
      send(pr, 0, "R3");

      // R4: maximum frame length, clean
      msg.delete();
      for (int i = 0; i < 32; i++) msg.push_back(1'(i % 3 == 1));
      encode(msg, pr);
      send(pr, 0, "R4");

      // R5: one- and two-pair frames
      pr = '{2'b11, 2'b10};
      send(pr, 0, "R5");
      pr = '{2'b01};
      send(pr, 0, "R5");

      // R6: junk pairs while emitting, then a following frame
      msg = '{1, 1, 0, 1, 0, 0, 1};
      encode(msg, pr);
      send(pr, 1, "R6");
      msg = '{0, 1, 1, 0, 1};
      encode(msg, pr);
      send(pr, 0, "R6");

      // R7: back-to-back frames with distinct content
      msg = '{1, 1, 1, 1, 1, 1};
      encode(msg, pr);
      pr[3] ^= 2'b11;
      send(pr, 0, "R7");
      msg = '{0, 0, 1, 0};
      encode(msg, pr);
      send(pr, 0, "R7");

      // R8: long frame of inverted pairs, large accumulated distances
      msg.delete();
      for (int i = 0; i < 32; i++) msg.push_back(1'(i[1]));
      encode(msg, pr);
      foreach (pr[i]) pr[i] = ~pr[i];
      send(pr, 0, "R8");

      repeat (4) @(negedge clk);
      summary();
   end

endmodule